// File: doc/BRIEF.md
# MDIO Paged Register Bridge

This block sits on a management data line as a slave and opens a 32-bit register space, with 19-bit byte addresses, to a host that only issues ordinary 16-bit clause-22 management frames. The upper two bits of the frame's PHY-address field pick what a frame means: it may set the page, access one half of a 32-bit register, or belong to a real PHY further down the line. The page value supplies the upper address bits. The lower address bits come from the rest of the PHY-address field and from the register number.

Each 32-bit register is reached as two 16-bit halves. The low half sits at the assembled address and the high half sits at that address plus 2. Software writes the high half first, and the bridge only holds it in a staging register. The low-half write then sends one 32-bit write, so a trigger bit in the low half always finds its companion high half already in place. Software reads the low half first. That read fetches the full word over the internal bus and keeps a snapshot of it, and the high-half read that follows is answered from the snapshot.

The management clock is sampled in the system clock domain, so it must run several times slower than the system clock. The internal bus sends a request with valid/ready. The request stays stable until it is accepted. Only reads get a response, a single-cycle pulse with no back-pressure. For a read, the response must come back within one management clock period after the request is accepted, so that the data is ready for the turnaround.

Top module: `mdio_paged_bridge`

## Requirements
- R1: While reset is asserted, the bridge does not drive the data line and has no request outstanding, and reset clears the page to zero.
- R2: Bits 4:3 of the PHY-address field select the mode: 3 = page select, 2 = register access, 0 or 1 = not for the bridge. The opcode is 01 for a write and 10 for a read. Start is 01, and the header after start is opcode, PHY address and register number, each most significant bit first.
- R3: A page-select write takes only bits 9:0 of the 16-bit data as the page. Bits 15:10 are ignored.
- R4: A register-access request carries the address {page, PHY-address bits 2:0, register-number bits 4:1, 2'b00}. The page fills bits 18:9, and the low two bits are always zero.
- R5: A register write with register-number bit 0 = 1 (high half) only stages its data. It issues no bus request. A later high-half write replaces the staged value.
- R6: A register write with register-number bit 0 = 0 (low half) issues exactly one 32-bit write whose data is {staged high half, written low half}.
- R7: A register read of the low half issues exactly one bus read and returns bits 15:0 of the response in that same frame.
- R8: A register read of the high half issues no bus request and returns bits 31:16 of the word captured by the most recent low-half read.
- R9: A page-select read returns the page, zero-extended to 16 bits.
- R10: In modes 0 and 1 the bridge never drives the line and never issues a bus request. The downstream clock and data outputs follow the host lines at all times. When the bridge is not driving, the host data output and its enable come from the downstream port.
- R11: A bus request holds valid, write flag, address and data unchanged until ready is seen.
- R12: On a bridge read, the line is released during the first turnaround bit and driven low during the second. The 16 data bits follow, most significant first, and the line is released after the last bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mdc_i | input | 1 | Management clock from the host |
| mdio_i | input | 1 | Management data from the host |
| mdio_o | output | 1 | Management data toward the host |
| mdio_oe_o | output | 1 | Output enable for mdio_o |
| phy_mdc_o | output | 1 | Management clock forwarded downstream |
| phy_mdio_o | output | 1 | Management data forwarded downstream |
| phy_mdio_i | input | 1 | Data returned by the downstream PHY |
| phy_mdio_oe_i | input | 1 | Output enable of the downstream PHY |
| bus_req_valid_o | output | 1 | Internal request valid |
| bus_req_ready_i | input | 1 | Internal request accepted |
| bus_req_write_o | output | 1 | 1 = write, 0 = read |
| bus_req_addr_o | output | PAGE_W+9 | Word-aligned register byte address |
| bus_req_wdata_o | output | 32 | Write data |
| bus_rsp_valid_i | input | 1 | Read response strobe |
| bus_rsp_rdata_i | input | 32 | Read response data |

## Verification
If the page register is wrong, every later register request shows wrong upper address bits, and this is visible on the next accepted request, within one frame. A staging register that is lost or cleared too early shows up in the data of the very next low-half write. A stale or torn snapshot shows up as a high-half read that disagrees with the word the bus returned one frame earlier. If the frame counter drifts by even one bit, the turnaround low and the data bits move by one management clock, and the data word read back in that same frame is wrong.

// File: rtl/mdio_bridge_pkg.sv
package mdio_bridge_pkg;
  localparam int PHYAD_W = 5;
  localparam int REGAD_W = 5;
  localparam int HALF_W  = 16;
  localparam int WORD_W  = 2 * HALF_W;
  localparam int HDR_W   = 2 + PHYAD_W + REGAD_W;

  localparam logic [1:0] OP_WRITE = 2'b01;
  localparam logic [1:0] OP_READ  = 2'b10;

  typedef enum logic [1:0] {
    MODE_BYPASS = 2'd0,
    MODE_RSVD   = 2'd1,
    MODE_REG    = 2'd2,
    MODE_PAGE   = 2'd3
  } bridge_mode_e;

  typedef enum logic [2:0] {
    FR_IDLE,
    FR_START,
    FR_HDR,
    FR_TA,
    FR_DATA
  } frame_state_e;
endpackage

// File: rtl/mdio_pin_sync.sv
module mdio_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mdc_i,
  input  logic mdio_i,
  output logic mdc_rise,
  output logic mdio_bit
);
  logic [STAGES:0]   mdc_q;
  logic [STAGES-1:0] mdio_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mdc_q  <= '1;
      mdio_q <= '1;
    end else begin
      mdc_q  <= (STAGES+1)'({mdc_q, mdc_i});
      mdio_q <= STAGES'({mdio_q, mdio_i});
    end
  end

  // data and clock pass through the same number of stages
  assign mdc_rise = mdc_q[STAGES-1] & ~mdc_q[STAGES];
  assign mdio_bit = mdio_q[STAGES-1];
endmodule

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine
  import mdio_bridge_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                mdc_rise,
  input  logic                mdio_bit,
  input  logic                rd_claim,
  input  logic [HALF_W-1:0]   rd_half,
  output logic                hdr_done,
  output logic [1:0]          hdr_op,
  output logic [PHYAD_W-1:0]  hdr_phy,
  output logic [REGAD_W-1:0]  hdr_reg,
  output logic                wr_done,
  output logic [HALF_W-1:0]   wr_half,
  output logic                drv_o,
  output logic                drv_oe
);
  frame_state_e      state;
  logic [3:0]        cnt;
  logic [HDR_W-1:0]  hdr_sr;
  logic [HALF_W-1:0] in_sr;
  logic [HALF_W-1:0] out_sr;

  assign hdr_op  = hdr_sr[HDR_W-1 -: 2];
  assign hdr_phy = hdr_sr[REGAD_W +: PHYAD_W];
  assign hdr_reg = hdr_sr[REGAD_W-1:0];
  assign wr_half = in_sr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= FR_IDLE;
      cnt      <= '0;
      hdr_sr   <= '0;
      in_sr    <= '0;
      out_sr   <= '0;
      hdr_done <= 1'b0;
      wr_done  <= 1'b0;
      drv_o    <= 1'b1;
      drv_oe   <= 1'b0;
    end else begin
      hdr_done <= 1'b0;
      wr_done  <= 1'b0;
      if (mdc_rise) begin
        unique case (state)
          FR_IDLE: if (!mdio_bit) state <= FR_START;
          FR_START: begin
            cnt   <= '0;
            state <= mdio_bit ? FR_HDR : FR_IDLE;
          end
          FR_HDR: begin
            hdr_sr <= {hdr_sr[HDR_W-2:0], mdio_bit};
            cnt    <= cnt + 4'd1;
            if (cnt == 4'(HDR_W-1)) begin
              state    <= FR_TA;
              cnt      <= '0;
              hdr_done <= 1'b1;
            end
          end
          FR_TA: begin
            if (cnt == 4'd0) begin
              cnt <= 4'd1;
              if (rd_claim) begin
                drv_oe <= 1'b1;
                drv_o  <= 1'b0;
              end
            end else begin
              state  <= FR_DATA;
              cnt    <= '0;
              out_sr <= rd_half;
              if (drv_oe) drv_o <= rd_half[HALF_W-1];
            end
          end
          FR_DATA: begin
            in_sr <= {in_sr[HALF_W-2:0], mdio_bit};
            cnt   <= cnt + 4'd1;
            if (drv_oe) begin
              out_sr <= {out_sr[HALF_W-2:0], 1'b0};
              drv_o  <= out_sr[HALF_W-2];
            end
            if (cnt == 4'(HALF_W-1)) begin
              state   <= FR_IDLE;
              drv_oe  <= 1'b0;
              drv_o   <= 1'b1;
              wr_done <= (hdr_op == OP_WRITE);
            end
          end
          default: state <= FR_IDLE;
        endcase
      end
    end
  end
endmodule

// File: rtl/mdio_bridge_core.sv
module mdio_bridge_core
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W = 10,
  localparam int ADDR_W = PAGE_W + 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                hdr_done,
  input  logic [1:0]          hdr_op,
  input  logic [PHYAD_W-1:0]  hdr_phy,
  input  logic [REGAD_W-1:0]  hdr_reg,
  input  logic                wr_done,
  input  logic [HALF_W-1:0]   wr_half,
  output logic                rd_claim,
  output logic [HALF_W-1:0]   rd_half,
  output logic                req_valid,
  input  logic                req_ready,
  output logic                req_write,
  output logic [ADDR_W-1:0]   req_addr,
  output logic [WORD_W-1:0]   req_wdata,
  input  logic                rsp_valid,
  input  logic [WORD_W-1:0]   rsp_rdata
);
  bridge_mode_e      mode;
  logic              hi_sel;
  logic [ADDR_W-1:0] word_addr;
  logic [PAGE_W-1:0] page;
  logic [HALF_W-1:0] hi_stage;
  logic [WORD_W-1:0] snap;
  logic              await_rsp;

  assign mode      = bridge_mode_e'(hdr_phy[PHYAD_W-1 -: 2]);
  assign hi_sel    = hdr_reg[0];
  assign word_addr = {page, hdr_phy[2:0], hdr_reg[REGAD_W-1:1], 2'b00};
  assign rd_claim  = (hdr_op == OP_READ) && (mode == MODE_REG || mode == MODE_PAGE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      page      <= '0;
      hi_stage  <= '0;
      snap      <= '0;
      rd_half   <= '0;
      await_rsp <= 1'b0;
      req_valid <= 1'b0;
      req_write <= 1'b0;
      req_addr  <= '0;
      req_wdata <= '0;
    end else begin
      if (req_valid && req_ready) req_valid <= 1'b0;

      if (await_rsp && rsp_valid) begin
        snap      <= rsp_rdata;
        rd_half   <= rsp_rdata[HALF_W-1:0];
        await_rsp <= 1'b0;
      end

      if (hdr_done && hdr_op == OP_READ) begin
        if (mode == MODE_PAGE) begin
          rd_half <= HALF_W'(page);
        end else if (mode == MODE_REG) begin
          if (hi_sel) begin
            rd_half <= snap[WORD_W-1:HALF_W];
          end else begin
            req_valid <= 1'b1;
            req_write <= 1'b0;
            req_addr  <= word_addr;
            req_wdata <= '0;
            await_rsp <= 1'b1;
          end
        end
      end

      if (wr_done) begin
        if (mode == MODE_PAGE) begin
          page <= wr_half[PAGE_W-1:0];
        end else if (mode == MODE_REG) begin
          if (hi_sel) begin
            hi_stage <= wr_half;
          end else begin
            req_valid <= 1'b1;
            req_write <= 1'b1;
            req_addr  <= word_addr;
            req_wdata <= {hi_stage, wr_half};
          end
        end
      end
    end
  end
endmodule

// File: rtl/mdio_paged_bridge.sv
module mdio_paged_bridge
  import mdio_bridge_pkg::*;
#(
  parameter int PAGE_W      = 10,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  mdc_i,
  input  logic                  mdio_i,
  output logic                  mdio_o,
  output logic                  mdio_oe_o,
  output logic                  phy_mdc_o,
  output logic                  phy_mdio_o,
  input  logic                  phy_mdio_i,
  input  logic                  phy_mdio_oe_i,
  output logic                  bus_req_valid_o,
  input  logic                  bus_req_ready_i,
  output logic                  bus_req_write_o,
  output logic [PAGE_W+8:0]     bus_req_addr_o,
  output logic [WORD_W-1:0]     bus_req_wdata_o,
  input  logic                  bus_rsp_valid_i,
  input  logic [WORD_W-1:0]     bus_rsp_rdata_i
);
  logic               mdc_rise, mdio_bit;
  logic               hdr_done, wr_done, rd_claim;
  logic [1:0]         hdr_op;
  logic [PHYAD_W-1:0] hdr_phy;
  logic [REGAD_W-1:0] hdr_reg;
  logic [HALF_W-1:0]  wr_half, rd_half;
  logic               drv_o, drv_oe;

  mdio_pin_sync #(.STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc_i), .mdio_i(mdio_i),
    .mdc_rise(mdc_rise), .mdio_bit(mdio_bit)
  );

  mdio_frame_engine frame_i (
    .clk(clk), .rst_n(rst_n), .mdc_rise(mdc_rise), .mdio_bit(mdio_bit),
    .rd_claim(rd_claim), .rd_half(rd_half),
    .hdr_done(hdr_done), .hdr_op(hdr_op), .hdr_phy(hdr_phy), .hdr_reg(hdr_reg),
    .wr_done(wr_done), .wr_half(wr_half), .drv_o(drv_o), .drv_oe(drv_oe)
  );

  mdio_bridge_core #(.PAGE_W(PAGE_W)) core_i (
    .clk(clk), .rst_n(rst_n),
    .hdr_done(hdr_done), .hdr_op(hdr_op), .hdr_phy(hdr_phy), .hdr_reg(hdr_reg),
    .wr_done(wr_done), .wr_half(wr_half),
    .rd_claim(rd_claim), .rd_half(rd_half),
    .req_valid(bus_req_valid_o), .req_ready(bus_req_ready_i),
    .req_write(bus_req_write_o), .req_addr(bus_req_addr_o),
    .req_wdata(bus_req_wdata_o),
    .rsp_valid(bus_rsp_valid_i), .rsp_rdata(bus_rsp_rdata_i)
  );

  assign phy_mdc_o  = mdc_i;
  assign phy_mdio_o = mdio_i;
  assign mdio_o     = drv_oe ? drv_o : phy_mdio_i;
  assign mdio_oe_o  = drv_oe | phy_mdio_oe_i;
endmodule

// File: rtl/mdio_paged_bridge_chk.sv
module mdio_paged_bridge_chk #(
  parameter int AW = 19
) (
  input logic          clk,
  input logic          rst_n,
  input logic          req_valid,
  input logic          req_ready,
  input logic          req_write,
  input logic [AW-1:0] req_addr,
  input logic [31:0]   req_wdata,
  input logic          drv_o,
  input logic          drv_oe
);
  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && !req_ready |=> req_valid && $stable(req_write)
      && $stable(req_addr) && $stable(req_wdata));

  // R4
  req_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> req_addr[1:0] == 2'b00);

  // R12
  ta_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(drv_oe) |-> !drv_o);

  // R1
  always @(negedge clk) begin
    if (!rst_n) begin
      reset_idle_chk: assert (!req_valid && !drv_oe);
    end
  end
endmodule

bind mdio_paged_bridge mdio_paged_bridge_chk #(.AW(PAGE_W + 9)) chk_i (
  .clk(clk), .rst_n(rst_n),
  .req_valid(bus_req_valid_o), .req_ready(bus_req_ready_i),
  .req_write(bus_req_write_o), .req_addr(bus_req_addr_o),
  .req_wdata(bus_req_wdata_o), .drv_o(drv_o), .drv_oe(drv_oe)
);

// File: tb/mdio_paged_bridge_tb.sv
module mdio_paged_bridge_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int HALF_MDC   = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mdc = 1'b1, mdio_i = 1'b1;
  logic mdio_o, mdio_oe_o, phy_mdc_o, phy_mdio_o;
  logic phy_mdio_i = 1'b1, phy_mdio_oe_i = 1'b0;
  logic bus_req_valid_o, bus_req_ready_i = 1'b0, bus_req_write_o;
  logic [18:0] bus_req_addr_o;
  logic [31:0] bus_req_wdata_o;
  logic bus_rsp_valid_i = 1'b0;
  logic [31:0] bus_rsp_rdata_i = '0;

  int checks = 0, errors = 0;
  int wr_count = 0, rd_count = 0, stall_n = 0, stall_cnt = 0, rsp_due = 0;
  int mirror_bad = 0;
  logic [18:0] last_wr_addr, last_rd_addr, cap_addr;
  logic [31:0] last_wr_data, cap_wdata, pend_rsp;
  logic cap_write;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mdio_paged_bridge dut_i (
    .clk(clk), .rst_n(rst_n), .mdc_i(mdc), .mdio_i(mdio_i),
    .mdio_o(mdio_o), .mdio_oe_o(mdio_oe_o),
    .phy_mdc_o(phy_mdc_o), .phy_mdio_o(phy_mdio_o),
    .phy_mdio_i(phy_mdio_i), .phy_mdio_oe_i(phy_mdio_oe_i),
    .bus_req_valid_o(bus_req_valid_o), .bus_req_ready_i(bus_req_ready_i),
    .bus_req_write_o(bus_req_write_o), .bus_req_addr_o(bus_req_addr_o),
    .bus_req_wdata_o(bus_req_wdata_o),
    .bus_rsp_valid_i(bus_rsp_valid_i), .bus_rsp_rdata_i(bus_rsp_rdata_i)
  );

  function automatic logic [31:0] model_val(logic [18:0] a, int n);
    return (32'(a) * 32'h9E37_79B1) ^ (32'(n) << 20);
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // internal bus model: configurable stall, read response two cycles later
  initial forever begin
    @(negedge clk);
    bus_rsp_valid_i = 1'b0;
    if (rsp_due > 0) begin
      rsp_due--;
      if (rsp_due == 0) begin
        bus_rsp_valid_i = 1'b1;
        bus_rsp_rdata_i = pend_rsp;
      end
    end
    if (bus_req_ready_i) begin
      bus_req_ready_i = 1'b0;
      if (cap_write) begin
        wr_count++; last_wr_addr = cap_addr; last_wr_data = cap_wdata;
      end else begin
        rd_count++; last_rd_addr = cap_addr;
        pend_rsp = model_val(cap_addr, rd_count); rsp_due = 2;
      end
    end else if (bus_req_valid_o) begin
      if (stall_cnt >= stall_n) begin
        bus_req_ready_i = 1'b1; stall_cnt = 0;
        cap_write = bus_req_write_o; cap_addr = bus_req_addr_o; cap_wdata = bus_req_wdata_o;
      end else stall_cnt++;
    end
  end

  task automatic host_bit(input logic b, output logic seen);
    mdc = 1'b0; mdio_i = b;
    repeat (HALF_MDC) @(negedge clk);
    seen = mdio_oe_o ? mdio_o : 1'b1;
    if (phy_mdc_o !== mdc || phy_mdio_o !== mdio_i) mirror_bad++;
    mdc = 1'b1;
    repeat (HALF_MDC) @(negedge clk);
    if (phy_mdc_o !== mdc) mirror_bad++;
  endtask

  task automatic frame(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, output logic [15:0] rd, output logic ta_low);
    logic [13:0] hdr;
    logic s;
    hdr = {2'b01, op, phy, rg};
    for (int i = 0; i < 32; i++) host_bit(1'b1, s);
    for (int i = 13; i >= 0; i--) host_bit(hdr[i], s);
    host_bit(op == 2'b01 ? 1'b1 : 1'b1, s);
    host_bit(op == 2'b01 ? 1'b0 : 1'b1, s);
    ta_low = (s == 1'b0);
    rd = '0;
    for (int i = 15; i >= 0; i--) begin
      host_bit(op == 2'b01 ? wd[i] : 1'b1, s);
      rd[i] = s;
    end
    host_bit(1'b1, s);
    host_bit(1'b1, s);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    logic ta;
    logic [9:0] pages [4];
    int wc, rc;
    logic [18:0] ea;
    logic [31:0] snapv;
    pages[0] = 10'h000; pages[1] = 10'h3FF; pages[2] = 10'h155; pages[3] = 10'h2AA;

    repeat (5) @(negedge clk);
    // R1 reset state
    check(mdio_oe_o == 1'b0, "R1 no drive in reset", 32'(mdio_oe_o), 0);
    check(bus_req_valid_o == 1'b0, "R1 no request in reset", 32'(bus_req_valid_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    for (int p = 0; p < 4; p++) begin
      // R3: upper data bits must be dropped
      wc = wr_count; rc = rd_count;
      frame(2'b01, 5'b11000, 5'd0, {6'b101101, pages[p]}, rd, ta);
      check(wr_count == wc && rd_count == rc, "R2 page write uses no bus", 32'(wr_count + rd_count), 32'(wc + rc));
      frame(2'b10, 5'b11000, 5'd0, 16'h0, rd, ta);
      check(rd == 16'(pages[p]), "R9 R3 page readback", 32'(rd), 32'(pages[p]));
      for (int ph = 0; ph < 8; ph++) begin
        logic [4:0] rg;
        rg = 5'((ph * 5 + p * 7) & 5'h1E);
        stall_n = ph % 4;
        ea = {pages[p], 3'(ph), rg[4:1], 2'b00};
        rc = rd_count;
        frame(2'b10, {2'b10, 3'(ph)}, rg, 16'h0, rd, ta);
        check(rd_count == rc + 1, "R7 one read per low half", 32'(rd_count), 32'(rc + 1));
        check(last_rd_addr == ea, "R4 assembled address", 32'(last_rd_addr), 32'(ea));
        snapv = model_val(ea, rc + 1);
        check(rd == snapv[15:0], "R7 low half data", 32'(rd), 32'(snapv[15:0]));
        check(ta, "R12 turnaround low", 32'(ta), 1);
        frame(2'b10, {2'b10, 3'(ph)}, rg | 5'd1, 16'h0, rd, ta);
        check(rd_count == rc + 1, "R8 no bus read on high half", 32'(rd_count), 32'(rc + 1));
        check(rd == snapv[31:16], "R8 snapshot high half", 32'(rd), 32'(snapv[31:16]));
      end
    end
    stall_n = 1;

    // R5 R6 write pairs, page is 2AA
    for (int k = 0; k < 4; k++) begin
      logic [15:0] hv, lv;
      hv = 16'hA000 + 16'(k * 16'h0111); lv = 16'h5000 ^ 16'(k * 16'h0B0D);
      wc = wr_count;
      frame(2'b01, {2'b10, 3'(k)}, 5'(k * 2 + 1), hv, rd, ta);
      check(wr_count == wc, "R5 high half only staged", 32'(wr_count), 32'(wc));
      frame(2'b01, {2'b10, 3'(k)}, 5'(k * 2), lv, rd, ta);
      ea = {10'h2AA, 3'(k), 4'(k), 2'b00};
      check(wr_count == wc + 1, "R6 single write on low half", 32'(wr_count), 32'(wc + 1));
      check(last_wr_addr == ea, "R6 R4 write address", 32'(last_wr_addr), 32'(ea));
      check(last_wr_data == {hv, lv}, "R6 write data", last_wr_data, {hv, lv});
    end
    frame(2'b01, 5'b10111, 5'd31, 16'h1111, rd, ta);
    frame(2'b01, 5'b10111, 5'd31, 16'h2222, rd, ta);
    frame(2'b01, 5'b10111, 5'd30, 16'h3333, rd, ta);
    check(last_wr_data == 32'h2222_3333, "R5 latest staged half used", last_wr_data, 32'h2222_3333);

    // R10 bypass and reserved modes
    wc = wr_count; rc = rd_count;
    phy_mdio_oe_i = 1'b1; phy_mdio_i = 1'b0;
    frame(2'b10, 5'b00011, 5'd2, 16'h0, rd, ta);
    check(rd == 16'h0000, "R10 downstream data reaches host", 32'(rd), 0);
    phy_mdio_oe_i = 1'b0; phy_mdio_i = 1'b1;
    frame(2'b10, 5'b01010, 5'd4, 16'h0, rd, ta);
    check(rd == 16'hFFFF, "R10 bridge silent in mode 1", 32'(rd), 32'hFFFF);
    frame(2'b01, 5'b00001, 5'd6, 16'h1234, rd, ta);
    frame(2'b01, 5'b01001, 5'd6, 16'h1234, rd, ta);
    check(wr_count == wc && rd_count == rc, "R10 no bus traffic in bypass", 32'(wr_count + rd_count), 32'(wc + rc));
    check(mirror_bad == 0, "R10 downstream mirrors host", 32'(mirror_bad), 0);

    // R1 reset clears page
    @(negedge clk); rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(mdio_oe_o == 1'b0 && bus_req_valid_o == 1'b0, "R1 idle under reset", 32'(mdio_oe_o), 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    frame(2'b10, 5'b10101, 5'd6, 16'h0, rd, ta);
    ea = {10'h000, 3'd5, 4'd3, 2'b00};
    check(last_rd_addr == ea, "R1 page cleared by reset", 32'(last_rd_addr), 32'(ea));

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule